// File: doc/BRIEF.md
# Reprogrammable Five-Lamp Arrow Sequencer

This block drives a five-lamp arrow sign from a two-bit Moore state machine. Both the transition function and the lamp function are held in small writable tables, not in fixed gates. A pattern can therefore be replaced at run time by rewriting table entries, with no change to the hardware. The transition table is indexed by the enable switch together with the current state. The lamp table is indexed by the state alone, so the lamps never depend directly on the inputs.

After reset, the tables hold a built-in pattern. The sign starts dark, lights the first pair of lamps, then four lamps, then all five, and loops for as long as the switch stays on. A tick-enable input decides which clock edges may advance the state, so the blink rate can be slower than the clock. Each table has one synchronous write port made of an enable, an address and data.

Top module: `sign_seq_top`

## Requirements
- R1: While reset is held and after it is released, the state is 00, both tables hold their built-in contents, and all three lamp outputs are 0.
- R2: With the built-in tables, `sw_on`=1 and `tick_en`=1, the state steps 00→01→10→11→00, one step per clock. The lamp bits {lamp_c,lamp_b,lamp_a} read 000, 001, 011, 111 for those states. lamp_a drives lamps 1–2, lamp_b drives lamps 3–4 and lamp_c drives lamp 5.
- R3: With the built-in tables, a clock edge with `sw_on`=0 and `tick_en`=1 sends the state to 00 from any state, and the lamps go dark.
- R4: On a clock edge with `tick_en`=0, the state holds and the lamps do not change.
- R5: The lamps equal the lamp-table entry addressed by the current state. A write through `ot_we`/`ot_addr`/`ot_wdata` is visible on the lamps from the cycle after the write edge.
- R6: On an advance, the next state is the transition-table entry at address {sw_on, state[1], state[0]}, with sw_on as the address MSB. Rewriting entries 4 and 6 to 10 and 00, and lamp entry 2 to 111, gives a two-state all-off/all-on loop.
- R7: When a transition-table write and an advance fall on the same edge, the advance uses the entry's old content, and the new content takes effect from the next edge.
- R8: A new reset after reprogramming restores both built-in tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_on | input | 1 | Sign enable switch, MSB of the transition-table lookup |
| tick_en | input | 1 | Allows the state to advance on this edge |
| ns_we | input | 1 | Transition-table write enable |
| ns_addr | input | 3 | Transition-table write address {switch, state} |
| ns_wdata | input | 2 | Transition-table write data (next state) |
| ot_we | input | 1 | Lamp-table write enable |
| ot_addr | input | 2 | Lamp-table write address (state) |
| ot_wdata | input | 3 | Lamp-table write data {c,b,a} |
| lamp_a | output | 1 | Drive for lamps 1 and 2 |
| lamp_b | output | 1 | Drive for lamps 3 and 4 |
| lamp_c | output | 1 | Drive for lamp 5 |

## Verification
An advance and a write to the very transition entry that the advance looks up can land on the same clock edge. The bench provokes this from state 00 with the switch on. It sets `ns_we` on address 4 in the same cycle as `tick_en`. The result is judged over the next three cycles: the first step must follow the old entry, and the step that revisits the entry must follow the new one. A lamp-table write while the state is held checks the parallel case on the output side.

// File: rtl/sign_seq_pkg.sv
package sign_seq_pkg;

  localparam int ST_W     = 2;
  localparam int OUT_W    = 3;
  localparam int NS_AW    = ST_W + 1;
  localparam int NS_DEPTH = 1 << NS_AW;
  localparam int OT_DEPTH = 1 << ST_W;

  typedef logic [ST_W-1:0]  state_t;
  typedef logic [OUT_W-1:0] lamps_t;

  // Built-in transition image: switch off -> 00, switch on -> state + 1 (wrapping)
  function automatic logic [NS_DEPTH*ST_W-1:0] dflt_next_img();
    logic [NS_DEPTH*ST_W-1:0] img;
    img = '0;
    for (int a = 0; a < NS_DEPTH; a++) begin
      logic [NS_AW-1:0] av;
      av = NS_AW'(a);
      if (av[NS_AW-1])
        img[a*ST_W +: ST_W] = ST_W'(av[ST_W-1:0] + 1'b1);
      else
        img[a*ST_W +: ST_W] = '0;
    end
    return img;
  endfunction

  // Built-in lamp image: state k lights the k lowest lamp groups
  function automatic logic [OT_DEPTH*OUT_W-1:0] dflt_out_img();
    logic [OT_DEPTH*OUT_W-1:0] img;
    img = '0;
    for (int s = 0; s < OT_DEPTH; s++) begin
      img[s*OUT_W +: OUT_W] = OUT_W'((1 << s) - 1);
    end
    return img;
  endfunction

endpackage

// File: rtl/sign_rst_sync.sv
module sign_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/sign_lut.sv
module sign_lut #(
  parameter int AW    = 2,
  parameter int WIDTH = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [(1<<AW)*WIDTH-1:0]    init_img,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [WIDTH-1:0]            wr_data,
  input  logic [AW-1:0]               rd_addr,
  output logic [WIDTH-1:0]            rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][WIDTH-1:0] mem_q;
  logic [DEPTH-1:0]            ent_we;

  always_comb begin
    ent_we = '0;
    if (wr_en) ent_we[wr_addr] = 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mem_q[i] <= init_img[i*WIDTH +: WIDTH];
      else if (ent_we[i]) mem_q[i] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data)); // R5

  AST_IDLE_TABLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q)); // R6

endmodule

// File: rtl/sign_state_reg.sv
module sign_state_reg
  import sign_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv_en,
  input  state_t nxt_lookup,
  output state_t state_q
);

  state_t state_d;

  always_comb begin
    state_d = state_q;
    if (adv_en) state_d = nxt_lookup;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(state_q)); // R4

endmodule

// File: rtl/sign_seq_top.sv
module sign_seq_top
  import sign_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_on,
  input  logic             tick_en,
  input  logic             ns_we,
  input  logic [NS_AW-1:0] ns_addr,
  input  logic [ST_W-1:0]  ns_wdata,
  input  logic             ot_we,
  input  logic [ST_W-1:0]  ot_addr,
  input  logic [OUT_W-1:0] ot_wdata,
  output logic             lamp_a,
  output logic             lamp_b,
  output logic             lamp_c
);

  logic       rst_n_i;
  state_t     state_q;
  state_t     nxt_lookup;
  lamps_t     lamp_word;
  logic [NS_AW-1:0] ns_rd_addr;

  sign_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign ns_rd_addr = {sw_on, state_q};

  sign_lut #(.AW(NS_AW), .WIDTH(ST_W)) u_next_tbl (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .init_img (dflt_next_img()),
    .wr_en    (ns_we),
    .wr_addr  (ns_addr),
    .wr_data  (ns_wdata),
    .rd_addr  (ns_rd_addr),
    .rd_data  (nxt_lookup)
  );

  sign_state_reg u_state (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .adv_en     (tick_en),
    .nxt_lookup (nxt_lookup),
    .state_q    (state_q)
  );

  sign_lut #(.AW(ST_W), .WIDTH(OUT_W)) u_lamp_tbl (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .init_img (dflt_out_img()),
    .wr_en    (ot_we),
    .wr_addr  (ot_addr),
    .wr_data  (ot_wdata),
    .rd_addr  (state_q),
    .rd_data  (lamp_word)
  );

  assign lamp_a = lamp_word[0];
  assign lamp_b = lamp_word[1];
  assign lamp_c = lamp_word[2];

  AST_ADVANCE_FOLLOWS_TABLE: assert property (@(posedge clk) disable iff (!rst_n_i)
    tick_en |=> state_q == $past(nxt_lookup)); // R6

  AST_LAMPS_STATE_ONLY: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!tick_en && !ot_we) |=> $stable({lamp_c, lamp_b, lamp_a})); // R5

endmodule

// File: tb/sign_seq_top_tb.sv
module sign_seq_top_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sw_on = 1'b0, tick_en = 1'b0;
  logic       ns_we = 1'b0, ot_we = 1'b0;
  logic [2:0] ns_addr = '0;
  logic [1:0] ns_wdata = '0, ot_addr = '0;
  logic [2:0] ot_wdata = '0;
  logic       lamp_a, lamp_b, lamp_c;

  int total = 0;
  int bad = 0;
  bit run_chk = 0;
  string cur_req = "R1";

  // reference model
  logic [1:0] ns_m [8];
  logic [2:0] ot_m [4];
  logic [1:0] st_m;

  always #4 clk = ~clk;

  sign_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .sw_on(sw_on), .tick_en(tick_en),
    .ns_we(ns_we), .ns_addr(ns_addr), .ns_wdata(ns_wdata),
    .ot_we(ot_we), .ot_addr(ot_addr), .ot_wdata(ot_wdata),
    .lamp_a(lamp_a), .lamp_b(lamp_b), .lamp_c(lamp_c)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < 8; a++) ns_m[a] = (a >= 4) ? 2'((a + 1) % 4) : 2'd0;
      ot_m[0] = 3'b000; ot_m[1] = 3'b001; ot_m[2] = 3'b011; ot_m[3] = 3'b111;
      st_m = 2'd0;
    end else begin
      logic [1:0] nx;
      nx = ns_m[{sw_on, st_m}];
      if (tick_en) st_m = nx;
      if (ns_we) ns_m[ns_addr] = ns_wdata;
      if (ot_we) ot_m[ot_addr] = ot_wdata;
    end
  end

  always @(negedge clk) begin
    if (run_chk && rst_n) begin
      total++;
      if ({lamp_c, lamp_b, lamp_a} !== ot_m[st_m]) begin
        bad++;
        $display("FAIL %s model: got=%b exp=%b", cur_req, {lamp_c, lamp_b, lamp_a}, ot_m[st_m]);
      end
    end
  end

  task automatic chk(input string req, input logic [2:0] exp);
    total++;
    if ({lamp_c, lamp_b, lamp_a} !== exp) begin
      bad++;
      $display("FAIL %s: got=%b exp=%b", req, {lamp_c, lamp_b, lamp_a}, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    sw_on = 0; tick_en = 0; ns_we = 0; ot_we = 0;
    rst_n = 0;
    tick(3);
    rst_n = 1;
    tick(4);
  endtask

  initial begin
    rst_n = 0;
    cur_req = "R1";
    do_reset();
    run_chk = 1;
    chk("R1", 3'b000);

    // R2 default sequence
    cur_req = "R2";
    sw_on = 1; tick_en = 1;
    tick(1); chk("R2", 3'b001);
    tick(1); chk("R2", 3'b011);
    tick(1); chk("R2", 3'b111);
    tick(1); chk("R2", 3'b000);
    tick(1); chk("R2", 3'b001);
    tick(1); chk("R2", 3'b011);

    // R3 switch off from state 10
    cur_req = "R3";
    sw_on = 0;
    tick(1); chk("R3", 3'b000);

    // R4 hold without tick
    cur_req = "R4";
    sw_on = 1;
    tick(1); chk("R4", 3'b001);
    tick_en = 0;
    tick(1); chk("R4", 3'b001);
    tick(1); chk("R4", 3'b001);
    tick(1); chk("R4", 3'b001);

    // R5 lamp-table write while held in state 01
    cur_req = "R5";
    ot_we = 1; ot_addr = 2'd1; ot_wdata = 3'b101;
    tick(1); ot_we = 0;
    chk("R5", 3'b101);

    // R6 reprogram to two-state loop
    cur_req = "R6";
    sw_on = 0; tick_en = 1;
    tick(1); chk("R6", 3'b000);
    tick_en = 0;
    ns_we = 1; ns_addr = 3'd4; ns_wdata = 2'b10; tick(1);
    ns_addr = 3'd6; ns_wdata = 2'b00; tick(1);
    ns_we = 0;
    ot_we = 1; ot_addr = 2'd2; ot_wdata = 3'b111; tick(1);
    ot_we = 0;
    sw_on = 1; tick_en = 1;
    tick(1); chk("R6", 3'b111);
    tick(1); chk("R6", 3'b000);
    tick(1); chk("R6", 3'b111);
    tick(1); chk("R6", 3'b000);

    // R7 write to looked-up entry on the advancing edge
    cur_req = "R7";
    ns_we = 1; ns_addr = 3'd4; ns_wdata = 2'b01;
    tick(1); ns_we = 0;
    chk("R7", 3'b111);
    tick(1); chk("R7", 3'b000);
    tick(1); chk("R7", 3'b101);

    // R8 reset restores built-in tables
    cur_req = "R8";
    run_chk = 0;
    do_reset();
    run_chk = 1;
    chk("R8", 3'b000);
    sw_on = 1; tick_en = 1;
    tick(1); chk("R8", 3'b001);
    tick(1); chk("R8", 3'b011);
    tick(1); chk("R8", 3'b111);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1600000;
    total++; bad++;
    $display("FAIL watchdog: got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule